// File: doc/BRIEF.md
# Indexed Codec Control Register Interface

This block is the byte-wide host-facing register file of an audio codec. A host reaches it through four direct locations: an index pointer, a window onto the indexed control array, an interrupt status byte and a programmed-I/O data byte. The indexed window gives access to up to 32 eight-bit control registers. How many of them can be reached depends on an extended-mode bit held in one of those registers.

Each indexed register has its own write rule. The playback format register only accepts writes while a mode-change window is open. Some registers are read-only or reserved. One register has a single writable bit. A calibration-busy flag is reported for a fixed number of reads after the mode-change window opens.

The block also owns the interrupt state. A playback-complete event from the datapath raises it. The host acknowledges it in two ways: by writing the status location, or by clearing the playback flag in the alternate status register. Read data is registered and appears one cycle after the read strobe. A registered one-hot strobe tells neighbouring blocks which indexed register has just taken a new value.

Top module: `codec_regif`

## Requirements
- R1: Direct offsets 0, 1, 2 and 3 select index pointer, indexed data, status and PIO data. PIO data reads as 0x00 and writes to it are ignored. Status reads as {7'b0, INT}.
- R2: When bit 6 of index 12 is clear, only pointer bits 3:0 select the register. When it is set, pointer bits 4:0 select one of 32 registers.
- R3: After reset the index pointer reads 0x40, so the mode-change-enable bit (bit 6) is set. Bit 7 of the pointer is never stored and always reads 0.
- R4: With mode-change-enable set, a write to index 8 replaces the whole value. With it clear and bit 4 of index 24 set, only bits 7:4 change. Otherwise the write is dropped.
- R5: Bit 5 of index 9 is stored as 0 on every write.
- R6: Index 11 is read-only. A 0-to-1 change of mode-change-enable while index 9 bits 4:3 are nonzero loads a counter with CAL_READS. Each read of index 11 while the counter is nonzero returns bit 5 set and decrements the counter.
- R7: In index 12 only bit 6 is writable. The other bits stay at their reset value 0x8A.
- R8: Writes to indexes 22, 27 and 29 are ignored.
- R9: Any write to the status offset clears INT and bits 6:4 of index 24, and drops irq.
- R10: A write to index 24 that clears bit 4 while bit 4 was set clears INT and drops irq.
- R11: Reset values are 0x88 for indexes 2-5, 18 and 19. They are 0x80 for indexes 6-7, 0x08 for index 9, 0x8A for index 12, and 0xA0 for indexes 25 and 26. All other indexes reset to 0x00.
- R12: bus_rdata and bus_rvalid are registered. They are valid exactly in the cycle after bus_rd, and bus_rvalid is low otherwise.
- R13: reg_wr_stb bit n pulses for one cycle after an accepted write to index n. It is at most one-hot and stays 0 for ignored writes.
- R14: A play_evt pulse sets INT and bit 4 of index 24. irq follows INT. If an acknowledge and play_evt arrive in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Direct location offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| bus_rvalid | output | 1 | Marks bus_rdata valid |
| play_evt | input | 1 | Playback-complete event from the datapath |
| irq | output | 1 | Interrupt line, mirrors INT |
| reg_wr_stb | output | NREG | One-hot strobe for the indexed register just updated |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle. They also assume that play_evt is not pulsed in the same cycle as an acknowledge, because the status-clear property only applies when no event is present. The bench drives each access as a single one-cycle strobe from tasks that never overlap. It pulses play_evt only while the bus is idle. A host that broke this one-access-per-cycle rule would make the read and write paths race, and the properties do not cover that case.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;
  localparam int unsigned IDX_FMT  = 8;
  localparam int unsigned IDX_IFC  = 9;
  localparam int unsigned IDX_ERR  = 11;
  localparam int unsigned IDX_MODE = 12;
  localparam int unsigned IDX_AFS  = 24;

  typedef enum logic [1:0] {
    LOC_INDEX = 2'd0,
    LOC_DATA  = 2'd1,
    LOC_STAT  = 2'd2,
    LOC_PIO   = 2'd3
  } loc_e;

  function automatic logic [7:0] rst_val(input int unsigned i);
    if ((i >= 2 && i <= 5) || i == 18 || i == 19) return 8'h88;
    if (i == 6 || i == 7) return 8'h80;
    if (i == IDX_IFC) return 8'h08;
    if (i == IDX_MODE) return 8'h8A;
    if (i == 25 || i == 26) return 8'hA0;
    return 8'h00;
  endfunction

  function automatic logic is_reserved(input logic [4:0] i);
    return (i == 5'd22) || (i == 5'd27) || (i == 5'd29);
  endfunction
endpackage

// File: rtl/codec_regif_wrmerge.sv
module codec_regif_wrmerge
  import codec_regif_pkg::*;
(
  input  logic [4:0] idx,
  input  logic [7:0] wdata,
  input  logic [7:0] old_val,
  input  logic       mce,
  input  logic       pmce,
  output logic       accept,
  output logic [7:0] new_val
);
  always_comb begin
    accept  = 1'b1;
    new_val = wdata;
    if (is_reserved(idx) || idx == 5'(IDX_ERR)) begin
      accept = 1'b0;
    end else if (idx == 5'(IDX_FMT)) begin
      if (mce) begin
        new_val = wdata;
      end else if (pmce) begin
        new_val = {wdata[7:4], old_val[3:0]};
      end else begin
        accept = 1'b0;
      end
    end else if (idx == 5'(IDX_IFC)) begin
      new_val = wdata & 8'hDF;
    end else if (idx == 5'(IDX_MODE)) begin
      new_val = {old_val[7], wdata[6], old_val[5:0]};
    end
  end
endmodule

// File: rtl/codec_regif_calcnt.sv
module codec_regif_calcnt #(
  parameter int unsigned CAL_READS = 1,
  localparam int unsigned CNT_W = $clog2(CAL_READS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic consume,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(CAL_READS);
    end else if (consume && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int unsigned NREG      = 32,
  parameter int unsigned CAL_READS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            bus_rvalid,
  input  logic            play_evt,
  output logic            irq,
  output logic [NREG-1:0] reg_wr_stb
);
  logic [7:0] regs [NREG];
  logic [6:0] index_q;
  logic       int_q;
  logic [4:0] idx_sel;
  logic       ext_mode, mce;
  logic       wr_ptr, wr_dat, wr_stat, rd_dat;
  logic       acc;
  logic [7:0] merged;
  logic       cal_busy, cal_load;
  logic       unused_wd7;

  assign unused_wd7 = bus_wdata[7];
  assign ext_mode = regs[IDX_MODE][6];
  assign mce      = index_q[6];
  assign idx_sel  = ext_mode ? index_q[4:0] : {1'b0, index_q[3:0]};

  assign wr_ptr  = bus_wr && bus_addr == LOC_INDEX;
  assign wr_dat  = bus_wr && bus_addr == LOC_DATA;
  assign wr_stat = bus_wr && bus_addr == LOC_STAT;
  assign rd_dat  = bus_rd && bus_addr == LOC_DATA;

  codec_regif_wrmerge u_merge (
    .idx     (idx_sel),
    .wdata   (bus_wdata),
    .old_val (regs[idx_sel]),
    .mce     (mce),
    .pmce    (regs[IDX_AFS][4]),
    .accept  (acc),
    .new_val (merged)
  );

  assign cal_load = wr_ptr && !mce && bus_wdata[6] && (regs[IDX_IFC][4:3] != 2'b00);

  codec_regif_calcnt #(.CAL_READS(CAL_READS)) u_cal (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cal_load),
    .consume (rd_dat && idx_sel == 5'(IDX_ERR)),
    .busy    (cal_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= 7'h40;
    end else if (wr_ptr) begin
      index_q <= bus_wdata[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(i);
    end else begin
      if (wr_dat && acc) regs[idx_sel] <= merged;
      if (wr_stat) regs[IDX_AFS][6:4] <= 3'b000;
      if (play_evt) regs[IDX_AFS][4] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q <= 1'b0;
    end else if (play_evt) begin
      int_q <= 1'b1;
    end else if (wr_stat) begin
      int_q <= 1'b0;
    end else if (wr_dat && idx_sel == 5'(IDX_AFS) && regs[IDX_AFS][4] && !bus_wdata[4]) begin
      int_q <= 1'b0;
    end
  end
  assign irq = int_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        unique case (bus_addr)
          LOC_INDEX: bus_rdata <= {1'b0, index_q};
          LOC_DATA:  bus_rdata <= (idx_sel == 5'(IDX_ERR))
                                  ? (regs[idx_sel] | {2'b00, cal_busy, 5'b0})
                                  : regs[idx_sel];
          LOC_STAT:  bus_rdata <= {7'b0, int_q};
          default:   bus_rdata <= 8'h00;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_stb
    always_ff @(posedge clk) begin
      if (!rst_n) reg_wr_stb[g] <= 1'b0;
      else        reg_wr_stb[g] <= wr_dat && acc && (idx_sel == 5'(g));
    end
  end
endmodule

// File: rtl/codec_regif_chk.sv
module codec_regif_chk #(
  parameter int unsigned NREG = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      bus_addr,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [7:0]      bus_rdata,
  input logic            bus_rvalid,
  input logic            play_evt,
  input logic            irq,
  input logic [NREG-1:0] reg_wr_stb,
  input logic [4:0]      idx_sel
);
  assert_ptr_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |=> !bus_rdata[7]);

  assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_rvalid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  assert_stat_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !play_evt) |=> !irq);

  assert_evt_irq_R14: assert property (@(posedge clk) disable iff (!rst_n)
    play_evt |=> irq);

  assert_stb_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wr_stb));

  assert_rsvd_nostb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 &&
     (idx_sel == 5'd22 || idx_sel == 5'd27 || idx_sel == 5'd29)) |=> (reg_wr_stb == '0));
endmodule

bind codec_regif codec_regif_chk #(.NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .play_evt   (play_evt),
  .irq        (irq),
  .reg_wr_stb (reg_wr_stb),
  .idx_sel    (idx_sel)
);

// File: tb/codec_regif_tb_top.sv
module codec_regif_tb_top;
  localparam int PERIOD = 10;
  localparam int NREG = 32;
  localparam int NVEC = 41;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic            bus_rvalid;
  logic            play_evt = 1'b0;
  logic            irq;
  logic [NREG-1:0] reg_wr_stb;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  codec_regif #(.NREG(NREG), .CAL_READS(1)) dut_i (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .bus_rdata, .bus_rvalid, .play_evt, .irq, .reg_wr_stb
  );

  // {read, offset, data, expected, requirement}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 8'h00, 8'h40, 4'd11}, // R11 R3 pointer reset
    {1'b0, 2'd0, 8'h8C, 8'h00, 4'd0},
    {1'b1, 2'd0, 8'h00, 8'h0C, 4'd3},  // R3 bit 7 dropped
    {1'b1, 2'd1, 8'h00, 8'h8A, 4'd11}, // R11 index 12
    {1'b0, 2'd1, 8'h75, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'hCA, 4'd7},  // R7 only bit 6
    {1'b0, 2'd0, 8'h16, 8'h00, 4'd0},
    {1'b0, 2'd1, 8'h55, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'h00, 4'd8},  // R8 index 22
    {1'b0, 2'd0, 8'h19, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'hA0, 4'd11}, // R11 index 25
    {1'b0, 2'd0, 8'h12, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'h88, 4'd11}, // R11 index 18
    {1'b0, 2'd0, 8'h08, 8'h00, 4'd0},
    {1'b0, 2'd1, 8'hFF, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'h00, 4'd4},  // R4 dropped
    {1'b0, 2'd0, 8'h18, 8'h00, 4'd0},
    {1'b0, 2'd1, 8'h10, 8'h00, 4'd0},
    {1'b0, 2'd0, 8'h08, 8'h00, 4'd0},
    {1'b0, 2'd1, 8'hAB, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'hA0, 4'd4},  // R4 upper nibble only
    {1'b0, 2'd0, 8'h48, 8'h00, 4'd0},
    {1'b0, 2'd1, 8'h3C, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'h3C, 4'd4},  // R4 whole write
    {1'b0, 2'd0, 8'h49, 8'h00, 4'd0},
    {1'b0, 2'd1, 8'hFF, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'hDF, 4'd5},  // R5
    {1'b0, 2'd3, 8'h77, 8'h00, 4'd0},
    {1'b1, 2'd3, 8'h00, 8'h00, 4'd1},  // R1 PIO
    {1'b1, 2'd2, 8'h00, 8'h00, 4'd1},  // R1 status
    {1'b0, 2'd0, 8'h4C, 8'h00, 4'd0},
    {1'b0, 2'd1, 8'h00, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'h8A, 4'd7},  // R7 bit 6 cleared
    {1'b0, 2'd0, 8'h59, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'hDF, 4'd2},  // R2 25 folds to 9
    {1'b0, 2'd0, 8'h4B, 8'h00, 4'd0},
    {1'b0, 2'd1, 8'hFF, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'h20, 4'd6},  // R6 busy once
    {1'b1, 2'd1, 8'h00, 8'h00, 4'd6},  // R6 count spent
    {1'b0, 2'd0, 8'h47, 8'h00, 4'd0},
    {1'b1, 2'd1, 8'h00, 8'h80, 4'd11}  // R11 index 7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    play_evt = 1'b1;
    @(negedge clk);
    play_evt = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 rvalid at reset", 32'(bus_rvalid), 0);
    check("R14 irq at reset", 32'(irq), 0);
    check("R13 strobe at reset", 32'(reg_wr_stb), 0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][22]) begin
        do_rd(VEC[i][21:20], rd);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), 32'(rd), 32'(VEC[i][11:4]));
        check("R12 rvalid after read", 32'(bus_rvalid), 1);
      end else begin
        do_wr(VEC[i][21:20], VEC[i][19:12]);
      end
    end

    // R12 rvalid drops when idle
    @(negedge clk);
    check("R12 rvalid idle", 32'(bus_rvalid), 0);

    // R13 strobe for accepted write to index 9
    do_wr(2'd0, 8'h49);
    do_wr(2'd1, 8'h18);
    check("R13 strobe index 9", 32'(reg_wr_stb), 32'h0000_0200);
    @(negedge clk);
    check("R13 strobe one cycle", 32'(reg_wr_stb), 0);

    // R8 reserved 27 in extended mode: no strobe, no change
    do_wr(2'd0, 8'h4C);
    do_wr(2'd1, 8'h40);
    do_wr(2'd0, 8'h5B);
    do_wr(2'd1, 8'h11);
    check("R8 no strobe on reserved", 32'(reg_wr_stb), 0);
    do_rd(2'd1, rd);
    check("R8 index 27 unchanged", 32'(rd), 0);

    // R14 event sets INT and index 24 bit 4
    pulse_evt();
    check("R14 irq raised", 32'(irq), 1);
    do_rd(2'd2, rd);
    check("R14 status INT", 32'(rd), 1);
    do_wr(2'd0, 8'h58);
    do_rd(2'd1, rd);
    check("R14 index 24 flag", 32'(rd), 32'h10);

    // R9 status write clears INT and flags
    do_wr(2'd1, 8'h70);
    check("R10 keep bit 4 no clear", 32'(irq), 1);
    do_wr(2'd2, 8'h00);
    check("R9 irq dropped", 32'(irq), 0);
    do_rd(2'd1, rd);
    check("R9 index 24 flags cleared", 32'(rd), 0);

    // R10 clearing bit 4 in index 24 acknowledges
    pulse_evt();
    check("R14 irq raised again", 32'(irq), 1);
    do_wr(2'd1, 8'h00);
    check("R10 irq dropped", 32'(irq), 0);
    do_rd(2'd2, rd);
    check("R10 status INT clear", 32'(rd), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule